// File: doc/BRIEF.md
# Interconnect Swap Sequencer

This block coordinates a run-time replacement of the on-chip interconnect. When a node reports that traffic between a given sender and receiver needs lower latency, a manager raises a help request carrying that pair. The sequencer then runs a fixed sequence. It broadcasts a pause so that every node and every peer manager stops injecting traffic. It waits a programmable number of cycles while packets already in flight reach their destinations. It then asks an external reconfiguration engine to load a stored network configuration with extra links, and once the swap is over it broadcasts a resume.

The configuration to load is chosen by a small priority lookup. The lookup maps the sender/receiver pair to a configuration index and falls back to a default index when no entry matches. If the engine does not report completion within a bounded number of cycles, the sequencer gives up. It restores the previously active index, resumes traffic and raises a sticky error flag. Help requests are taken only while the block is idle.

Top module: `netswap_coord`

## Requirements
- R1: During and straight after reset, pause_bcast, resume_bcast, reconf_req, busy and swap_err are 0 and cfg_idx equals BOOT_CFG (default 0).
- R2: A help_req sampled high while idle makes pause_bcast high for exactly one cycle, starting the cycle after the sampling edge, and busy goes high in that same cycle.
- R3: From the pause cycle, cfg_idx shows the index looked up from {help_src, help_dst}. With the default table, pair (1,15) gives 1, (1,10) gives 2 and (7,1) gives 3, and any other pair gives DEFAULT_CFG = 7. When several entries match, the lowest-numbered one wins: a fourth entry (1,15) gives 5 and is therefore never used.
- R4: reconf_req rises exactly drain_cycles + 2 cycles after pause_bcast rises, using the drain_cycles value sampled with the request. A value of 0 is allowed.
- R5: reconf_req stays high until reconf_done is sampled high. In the next cycle reconf_req is low and resume_bcast is high for one cycle, and cfg_idx keeps the new index. busy is low in the cycle after the resume pulse.
- R6: If reconf_done is not sampled within TIMEOUT_CYC cycles of reconf_req being high, reconf_req falls after exactly TIMEOUT_CYC cycles. In that same cycle resume_bcast pulses, swap_err goes high and cfg_idx returns to the index that was active before the request.
- R7: swap_err stays high while idle and is cleared in the pause cycle of the next accepted request.
- R8: A help_req that arrives while busy is ignored: no further pause pulse occurs and cfg_idx keeps the index of the sequence in progress.
- R9: reconf_done outside the swap phase is ignored. In idle it does not set busy or resume_bcast. During the drain it neither shortens the wait nor ends the swap.
- R10: At most one of pause_bcast, reconf_req and resume_bcast is high in any cycle, and reconf_req is high only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| help_req | input | 1 | Latency help request, sampled only when idle |
| help_src | input | NODE_W | Sender node of the congested pair |
| help_dst | input | NODE_W | Receiver node of the congested pair |
| drain_cycles | input | CNT_W | Drain interval in cycles, sampled with the request |
| pause_bcast | output | 1 | One-cycle pause command to nodes and peer managers |
| resume_bcast | output | 1 | One-cycle resume command to nodes and peer managers |
| cfg_idx | output | CFG_W | Index of the configuration selected or active |
| reconf_req | output | 1 | Request to the reconfiguration engine |
| reconf_done | input | 1 | Completion from the reconfiguration engine |
| busy | output | 1 | High from the pause cycle until the resume cycle |
| swap_err | output | 1 | Sticky flag set when the swap timed out |

## Verification
The lookup and the sequence are exercised together: every one of the 256 sender/receiver pairs runs a complete swap. Drain values vary over 0 to 3, and completion arrives 1 to 3 cycles into the request. This separates table hits, the priority between duplicate entries and the default fallback, and it confirms the drain count arithmetic at its zero edge. Some runs flood help_req and reconf_done during the drain, which shows whether a busy block can be retriggered or cut short. Timeout runs without completion, together with a 255-cycle drain, show the index restore, the sticky error flag and its clearing, as distinct from a normal finish.

// File: rtl/netswap_pkg.sv
package netswap_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_PAUSE  = 3'd1,
    ST_DRAIN  = 3'd2,
    ST_SWAP   = 3'd3,
    ST_RESUME = 3'd4
  } seq_state_t;
endpackage

// File: rtl/netswap_pairsel.sv
module netswap_pairsel #(
  parameter int NODE_W      = 4,
  parameter int CFG_W       = 3,
  parameter int NUM_PAIRS   = 4,
  parameter int DEFAULT_CFG = 7,
  localparam int ENT_W      = 2*NODE_W + CFG_W,
  parameter logic [NUM_PAIRS*ENT_W-1:0] PAIR_TABLE = '0
) (
  input  logic [NODE_W-1:0] src,
  input  logic [NODE_W-1:0] dst,
  output logic [CFG_W-1:0]  idx
);
  logic [NUM_PAIRS-1:0]            hit;
  logic [NUM_PAIRS-1:0][CFG_W-1:0] ent_idx;

  // Each entry: {src, dst, idx}, idx in the low bits.
  for (genvar g = 0; g < NUM_PAIRS; g++) begin : g_ent
    localparam logic [ENT_W-1:0] ENT = PAIR_TABLE[g*ENT_W +: ENT_W];
    assign hit[g]     = (src == ENT[ENT_W-1 -: NODE_W]) &&
                        (dst == ENT[CFG_W +: NODE_W]);
    assign ent_idx[g] = ENT[CFG_W-1:0];
  end

  // Lowest-numbered matching entry wins.
  always_comb begin
    idx = CFG_W'(DEFAULT_CFG);
    for (int i = NUM_PAIRS-1; i >= 0; i--) begin
      if (hit[i]) idx = ent_idx[i];
    end
  end
endmodule

// File: rtl/netswap_drain.sv
module netswap_drain #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             en,
  output logic             zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= load_val;
    else if (en && !zero)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/netswap_watchdog.sv
module netswap_watchdog #(
  parameter int TIMEOUT_CYC = 64,
  localparam int WD_W       = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic expired
);
  logic [WD_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !en)    cnt <= '0;
    else if (!expired) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == WD_W'(TIMEOUT_CYC - 1));
endmodule

// File: rtl/netswap_coord.sv
module netswap_coord
  import netswap_pkg::*;
#(
  parameter int NODE_W      = 4,
  parameter int CFG_W       = 3,
  parameter int CNT_W       = 8,
  parameter int NUM_PAIRS   = 4,
  parameter int TIMEOUT_CYC = 64,
  parameter int DEFAULT_CFG = 7,
  parameter int BOOT_CFG    = 0,
  localparam int ENT_W      = 2*NODE_W + CFG_W,
  parameter logic [NUM_PAIRS*ENT_W-1:0] PAIR_TABLE = {
    4'd1, 4'd15, 3'd5,
    4'd7, 4'd1,  3'd3,
    4'd1, 4'd10, 3'd2,
    4'd1, 4'd15, 3'd1
  }
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              help_req,
  input  logic [NODE_W-1:0] help_src,
  input  logic [NODE_W-1:0] help_dst,
  input  logic [CNT_W-1:0]  drain_cycles,
  output logic              pause_bcast,
  output logic              resume_bcast,
  output logic [CFG_W-1:0]  cfg_idx,
  output logic              reconf_req,
  input  logic              reconf_done,
  output logic              busy,
  output logic              swap_err
);
  seq_state_t       state;
  logic [CFG_W-1:0] sel_idx;
  logic [CFG_W-1:0] prev_idx;
  logic             accept;
  logic             drain_zero;
  logic             wd_expired;

  assign accept = (state == ST_IDLE) && help_req;

  netswap_pairsel #(
    .NODE_W(NODE_W), .CFG_W(CFG_W), .NUM_PAIRS(NUM_PAIRS),
    .DEFAULT_CFG(DEFAULT_CFG), .PAIR_TABLE(PAIR_TABLE)
  ) u_pairsel (
    .src(help_src), .dst(help_dst), .idx(sel_idx)
  );

  netswap_drain #(.CNT_W(CNT_W)) u_drain (
    .clk(clk), .rst(rst), .load(accept), .load_val(drain_cycles),
    .en(state == ST_DRAIN), .zero(drain_zero)
  );

  netswap_watchdog #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_wd (
    .clk(clk), .rst(rst), .en(state == ST_SWAP), .expired(wd_expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      pause_bcast  <= 1'b0;
      resume_bcast <= 1'b0;
      reconf_req   <= 1'b0;
      busy         <= 1'b0;
      swap_err     <= 1'b0;
      cfg_idx      <= CFG_W'(BOOT_CFG);
      prev_idx     <= CFG_W'(BOOT_CFG);
    end else begin
      pause_bcast  <= 1'b0;
      resume_bcast <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (help_req) begin
            state       <= ST_PAUSE;
            pause_bcast <= 1'b1;
            busy        <= 1'b1;
            swap_err    <= 1'b0;
            prev_idx    <= cfg_idx;
            cfg_idx     <= sel_idx;
          end
        end
        ST_PAUSE: state <= ST_DRAIN;
        ST_DRAIN: begin
          if (drain_zero) begin
            state      <= ST_SWAP;
            reconf_req <= 1'b1;
          end
        end
        ST_SWAP: begin
          if (reconf_done) begin
            state        <= ST_RESUME;
            reconf_req   <= 1'b0;
            resume_bcast <= 1'b1;
          end else if (wd_expired) begin
            state        <= ST_RESUME;
            reconf_req   <= 1'b0;
            resume_bcast <= 1'b1;
            swap_err     <= 1'b1;
            cfg_idx      <= prev_idx;
          end
        end
        ST_RESUME: begin
          state <= ST_IDLE;
          busy  <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/netswap_coord_chk.sv
module netswap_coord_chk #(
  parameter int CFG_W       = 3,
  parameter int TIMEOUT_CYC = 64,
  localparam int RUN_W      = $clog2(TIMEOUT_CYC + 2)
) (
  input logic             clk,
  input logic             rst,
  input logic             pause_bcast,
  input logic             resume_bcast,
  input logic             reconf_req,
  input logic             reconf_done,
  input logic             busy,
  input logic             swap_err,
  input logic [CFG_W-1:0] cfg_idx
);
  logic [RUN_W-1:0] req_run;

  always_ff @(posedge clk) begin
    if (rst)             req_run <= '0;
    else if (reconf_req) req_run <= req_run + 1'b1;
    else                 req_run <= '0;
  end

  assert_pause_pulse_R2: assert property (@(posedge clk) disable iff (rst)
    pause_bcast |=> !pause_bcast);

  assert_busy_with_pause_R2: assert property (@(posedge clk) disable iff (rst)
    pause_bcast |-> busy);

  assert_no_retrigger_R8: assert property (@(posedge clk) disable iff (rst)
    pause_bcast |-> !$past(busy));

  assert_done_ends_swap_R5: assert property (@(posedge clk) disable iff (rst)
    (reconf_req && reconf_done) |=> (!reconf_req && resume_bcast));

  assert_resume_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    resume_bcast |=> (!resume_bcast && !busy));

  assert_timeout_bound_R6: assert property (@(posedge clk) disable iff (rst)
    reconf_req |-> (req_run < RUN_W'(TIMEOUT_CYC)));

  assert_err_with_resume_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(swap_err) |-> resume_bcast);

  assert_idx_stable_swap_R3: assert property (@(posedge clk) disable iff (rst)
    (reconf_req && $past(reconf_req)) |-> $stable(cfg_idx));

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({pause_bcast, reconf_req, resume_bcast}));

  assert_req_in_busy_R10: assert property (@(posedge clk) disable iff (rst)
    reconf_req |-> busy);
endmodule

bind netswap_coord netswap_coord_chk #(
  .CFG_W(CFG_W), .TIMEOUT_CYC(TIMEOUT_CYC)
) u_chk (
  .clk(clk), .rst(rst), .pause_bcast(pause_bcast), .resume_bcast(resume_bcast),
  .reconf_req(reconf_req), .reconf_done(reconf_done), .busy(busy),
  .swap_err(swap_err), .cfg_idx(cfg_idx)
);

// File: tb/netswap_coord_tb.sv
module netswap_coord_tb;
  localparam int TO = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       help_req = 1'b0;
  logic [3:0] help_src = '0;
  logic [3:0] help_dst = '0;
  logic [7:0] drain_cycles = '0;
  logic       pause_bcast, resume_bcast, reconf_req, busy, swap_err;
  logic [2:0] cfg_idx;
  logic       reconf_done = 1'b0;

  int n_chk = 0;
  int n_bad = 0;
  int committed = 0;

  always #10 clk = ~clk;

  netswap_coord #(.TIMEOUT_CYC(TO)) u_dut (
    .clk(clk), .rst(rst), .help_req(help_req), .help_src(help_src),
    .help_dst(help_dst), .drain_cycles(drain_cycles),
    .pause_bcast(pause_bcast), .resume_bcast(resume_bcast),
    .cfg_idx(cfg_idx), .reconf_req(reconf_req), .reconf_done(reconf_done),
    .busy(busy), .swap_err(swap_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int lookup(input int s, input int d);
    if (s == 1 && d == 15) return 1;
    if (s == 1 && d == 10) return 2;
    if (s == 7 && d == 1)  return 3;
    return 7;
  endfunction

  // dly = 0 means never complete (timeout path).
  task automatic run_swap(input int s, input int d, input int dr,
                          input int dly, input bit poke);
    int exp_new = lookup(s, d);
    int t = 0;
    int h = 1;
    @(negedge clk);
    help_src = 4'(s); help_dst = 4'(d); drain_cycles = 8'(dr); help_req = 1'b1;
    @(negedge clk);
    help_req = 1'b0;
    chk(pause_bcast == 1'b1, "R2 pause", int'(pause_bcast), 1);
    chk(busy == 1'b1, "R2 busy", int'(busy), 1);
    chk(cfg_idx == 3'(exp_new), "R3 idx", int'(cfg_idx), exp_new);
    chk(swap_err == 1'b0, "R7 clear", int'(swap_err), 0);
    while (!reconf_req && t < 400) begin
      if (poke) begin
        help_src = 4'd7; help_dst = 4'd1; help_req = 1'b1; reconf_done = 1'b1;
      end
      @(negedge clk);
      t++;
      if (!reconf_req) begin
        chk(pause_bcast == 1'b0, "R8 no pause", int'(pause_bcast), 0);
        chk(cfg_idx == 3'(exp_new), "R8 idx", int'(cfg_idx), exp_new);
        chk(resume_bcast == 1'b0, "R9 no resume", int'(resume_bcast), 0);
      end
    end
    help_req = 1'b0; reconf_done = 1'b0;
    chk(t == dr + 2, "R4 drain", t, dr + 2);
    chk(pause_bcast == 1'b0 && resume_bcast == 1'b0, "R10 excl",
        int'({pause_bcast, resume_bcast}), 0);
    if (dly > 0) begin
      while (h < dly) begin
        @(negedge clk);
        chk(reconf_req == 1'b1, "R5 hold", int'(reconf_req), 1);
        h++;
      end
      reconf_done = 1'b1;
      @(negedge clk);
      reconf_done = 1'b0;
      chk(reconf_req == 1'b0, "R5 req drop", int'(reconf_req), 0);
      chk(resume_bcast == 1'b1, "R5 resume", int'(resume_bcast), 1);
      chk(cfg_idx == 3'(exp_new), "R5 idx kept", int'(cfg_idx), exp_new);
      chk(swap_err == 1'b0, "R5 no err", int'(swap_err), 0);
      committed = exp_new;
    end else begin
      while (reconf_req && h < 1000) begin
        @(negedge clk);
        if (reconf_req) h++;
      end
      chk(h == TO, "R6 window", h, TO);
      chk(resume_bcast == 1'b1, "R6 resume", int'(resume_bcast), 1);
      chk(swap_err == 1'b1, "R6 err", int'(swap_err), 1);
      chk(cfg_idx == 3'(committed), "R6 restore", int'(cfg_idx), committed);
    end
    @(negedge clk);
    chk(resume_bcast == 1'b0, "R5 resume pulse", int'(resume_bcast), 0);
    chk(busy == 1'b0, "R5 idle", int'(busy), 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && pause_bcast == 1'b0 && reconf_req == 1'b0, "R1 in reset",
        int'({busy, pause_bcast, reconf_req}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk({pause_bcast, resume_bcast, reconf_req, busy, swap_err} == 5'b0, "R1 outs",
        int'({pause_bcast, resume_bcast, reconf_req, busy, swap_err}), 0);
    chk(cfg_idx == 3'd0, "R1 idx", int'(cfg_idx), 0);

    // R9: completion while idle is ignored.
    reconf_done = 1'b1;
    repeat (3) @(negedge clk);
    reconf_done = 1'b0;
    chk(busy == 1'b0 && resume_bcast == 1'b0, "R9 idle done",
        int'({busy, resume_bcast}), 0);

    for (int s = 0; s < 16; s++) begin
      for (int d = 0; d < 16; d++) begin
        run_swap(s, d, (s + d) % 4, 1 + (s % 3), ((s * 16 + d) % 7) == 0);
      end
    end

    run_swap(1, 10, 5, 0, 1'b0);
    repeat (4) @(negedge clk);
    chk(swap_err == 1'b1, "R7 sticky", int'(swap_err), 1);
    chk(cfg_idx == 3'(committed), "R6 idle idx", int'(cfg_idx), committed);

    run_swap(7, 1, 255, 2, 1'b1);
    run_swap(1, 15, 0, 0, 1'b0);
    run_swap(3, 3, 0, 1, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule